// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer Controller

This block guards a processor system against software that has stopped running its service loop. A free-running counter measures system clocks against a time-out chosen by a three-bit field. When the counter reaches the time-out, the block takes one of two actions. It can pulse a non-maskable interrupt request. It can also issue a one-cycle internal reset request and hold a reset-out pin high for a long, fixed time so that external devices can settle. A sticky cause flag records which of the two actions happened.

All software access goes through one control register on a small register bus. A write counts only when it directly follows a two-word enable key. The counter restarts only on a separate two-word restart key, or on the write that first enables the watchdog. Software may rewrite the configuration as often as it likes until it writes the enable bit. From then on the register is locked, and only the cause flags can still be cleared. A watchdog reset puts the configuration back to its defaults but keeps both cause flags, so software can read the cause after the reset.

Top module: `wdt_ctrl`

## Requirements
- R1: After the external reset the register at CTL_ADDR reads 16'h8000 | DEF_SEL, and nmi_req, sys_rst_req and rst_out are low. The layout is bit 15 enable, bit 14 NMI cause flag, bit 13 reset cause flag, bit 3 action (1 = NMI, 0 = reset), bits 2:0 time-out select, and all other bits read 0. The watchdog counts from the reset release in reset action.
- R2: A write changes the register only when the two writes just before it, both to CTL_ADDR, were 16'h3333 and then 16'hCCCC. The key grants exactly one write. Any other value in the middle of a key aborts it, and a write without the key changes nothing.
- R3: Writing 16'hAAAA and then 16'h5555 to CTL_ADDR clears the counter. No other write, key attempt or write to another address restarts the count.
- R4: A time-out occurs 2^(TAP_BASE + 2*select) clock cycles after the edge on which the counter was last cleared. The action output is registered and goes high on that edge.
- R5: Until the register is locked, keyed writes may change enable, action and select any number of times. While enable is 0, no time-out occurs.
- R6: A keyed write with bit 15 set locks the register and clears the counter. After that, keyed writes cannot change enable, action or select.
- R7: In NMI action, a time-out with the NMI flag clear pulses nmi_req for one cycle, sets the NMI flag, and does not raise a reset.
- R8: In NMI action, a time-out while the NMI flag is already set raises a reset instead.
- R9: A reset time-out pulses sys_rst_req for one cycle and sets the reset flag. It also drives rst_out high for exactly RST_LEN cycles, starting on the same edge.
- R10: A keyed write of 0 to bit 14 or bit 13 clears that flag, and writing 1 leaves it as it is. Software can never set a flag. Both flags survive a watchdog reset, and the external reset clears them.
- R11: A watchdog reset restores enable, reset action, DEF_SEL and the unlocked state. While rst_out is high, bus writes are ignored and the counter stays at zero. Counting resumes from zero on the edge where rst_out falls.
- R12: The bus ignores writes to any address other than CTL_ADDR, and such addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | External reset, synchronous, active high |
| addr | input | ADDR_W | Register bus address |
| wdata | input | 16 | Register bus write data |
| wr | input | 1 | Write strobe, one write per cycle |
| rdata | output | 16 | Read data for the addressed register |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| sys_rst_req | output | 1 | One-cycle internal system reset request |
| rst_out | output | 1 | Stretched reset pulse for external devices |

## Verification
The checker watches rules that must hold on every cycle:
- a cause flag rises only together with its own action pulse;
- the two action pulses never coincide and each lasts one cycle;
- a reset pulse always starts rst_out, which never stays high longer than RST_LEN;
- the lock holds until a watchdog reset.

The bench scenarios cover the rest:
- exact time-out periods for each select value;
- rejection of broken or missing keys;
- the fact that ordinary traffic never restarts the count;
- escalation from NMI to reset;
- write-0-to-clear flags;
- the configuration restored after a watchdog reset.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int DW    = 16;
    localparam int SEL_W = 3;

    // key words
    localparam logic [DW-1:0] KEY_WR_A = 16'h3333;
    localparam logic [DW-1:0] KEY_WR_B = 16'hCCCC;
    localparam logic [DW-1:0] KEY_RS_A = 16'hAAAA;
    localparam logic [DW-1:0] KEY_RS_B = 16'h5555;

    // control register bit positions
    localparam int B_EN   = 15;
    localparam int B_NFLG = 14;
    localparam int B_RFLG = 13;
    localparam int B_ACT  = 3;

    typedef enum logic {
        ACT_RESET = 1'b0,
        ACT_NMI   = 1'b1
    } wdt_act_e;

    typedef struct packed {
        logic                 en;
        wdt_act_e             act;
        logic [SEL_W-1:0]     sel;
    } wdt_cfg_t;

    typedef struct packed {
        logic nmi;
        logic rst;
    } wdt_flags_t;

    // decoded data of a granted write
    typedef struct packed {
        logic                 en;
        logic                 keep_nmi;
        logic                 keep_rst;
        wdt_act_e             act;
        logic [SEL_W-1:0]     sel;
    } wdt_wr_t;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_WR1,
        KS_ARMED,
        KS_RS1
    } ks_state_e;

    function automatic int unsigned tap_bits(input int unsigned base,
                                             input logic [SEL_W-1:0] sel);
        return base + 2 * int'(sel);
    endfunction

    function automatic wdt_cfg_t cfg_default(input logic [SEL_W-1:0] s);
        wdt_cfg_t c;
        c.en  = 1'b1;
        c.act = ACT_RESET;
        c.sel = s;
        return c;
    endfunction

    function automatic wdt_wr_t decode_wr(input logic [DW-1:0] d);
        wdt_wr_t w;
        w.en       = d[B_EN];
        w.keep_nmi = d[B_NFLG];
        w.keep_rst = d[B_RFLG];
        w.act      = wdt_act_e'(d[B_ACT]);
        w.sel      = d[SEL_W-1:0];
        return w;
    endfunction

    function automatic logic [DW-1:0] pack_ctl(input wdt_cfg_t c, input wdt_flags_t f);
        return {c.en, f.nmi, f.rst, 9'b0, c.act, c.sel};
    endfunction

endpackage

// File: rtl/wdt_keyseq.sv
`timescale 1ns/1ps
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output logic          wr_grant,
    output logic          restart
);

    ks_state_e st, st_nx;

    always_comb begin
        st_nx    = st;
        wr_grant = 1'b0;
        restart  = 1'b0;
        if (wr_ctl) begin
            case (st)
                KS_IDLE: begin
                    if (wdata == KEY_WR_A)      st_nx = KS_WR1;
                    else if (wdata == KEY_RS_A) st_nx = KS_RS1;
                end
                KS_WR1:   st_nx = (wdata == KEY_WR_B) ? KS_ARMED : KS_IDLE;
                KS_ARMED: begin
                    wr_grant = 1'b1;
                    st_nx    = KS_IDLE;
                end
                KS_RS1: begin
                    restart = (wdata == KEY_RS_B);
                    st_nx   = KS_IDLE;
                end
                default:  st_nx = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) st <= KS_IDLE;
        else              st <= st_nx;
    end

endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter logic [SEL_W-1:0] DEF_SEL = '1
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       wr_grant,
    input  wdt_wr_t    wr_data,
    input  logic       set_nmi,
    input  logic       set_rst,
    output wdt_cfg_t   cfg,
    output wdt_flags_t flags,
    output logic       locked,
    output logic       arm_pulse
);

    logic clr_nmi, clr_rst;

    assign arm_pulse = wr_grant && !locked && wr_data.en;
    assign clr_nmi   = wr_grant && !wr_data.keep_nmi;
    assign clr_rst   = wr_grant && !wr_data.keep_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= cfg_default(DEF_SEL);
            flags  <= '0;
            locked <= 1'b0;
        end else begin
            if (soft_rst) begin
                cfg    <= cfg_default(DEF_SEL);
                locked <= 1'b0;
            end else if (wr_grant && !locked) begin
                cfg.en  <= wr_data.en;
                cfg.act <= wr_data.act;
                cfg.sel <= wr_data.sel;
                locked  <= wr_data.en;
            end
            // a set on the same edge wins over a clear
            flags.nmi <= set_nmi || (flags.nmi && !clr_nmi);
            flags.rst <= set_rst || (flags.rst && !clr_rst);
        end
    end

endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int TAP_BASE = 10
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int CW = TAP_BASE + 2 * ((1 << SEL_W) - 1) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;

    always_comb lim_m1 = (CW'(1) << tap_bits(TAP_BASE, sel)) - CW'(1);

    assign expire = run && !clr && (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst || clr || expire) cnt <= '0;
        else if (run)             cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/wdt_rstgen.sv
`timescale 1ns/1ps
module wdt_rstgen #(
    parameter int unsigned RST_LEN = 65536
)(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic rst_out
);

    localparam int RW = $clog2(RST_LEN + 1);

    logic [RW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (fire)        left <= RW'(RST_LEN);
        else if (left != '0)  left <= left - RW'(1);
    end

    assign rst_out = (left != '0);

endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTL_ADDR = '0,
    parameter int               TAP_BASE = 10,
    parameter int unsigned      RST_LEN  = 65536,
    parameter logic [SEL_W-1:0] DEF_SEL  = 3'd7
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr,
    output logic [DW-1:0]     rdata,
    output logic              nmi_req,
    output logic              sys_rst_req,
    output logic              rst_out
);

    wdt_cfg_t   cfg;
    wdt_flags_t flags;
    logic       locked, arm_pulse;
    logic       hit_ctl, wr_ctl, wr_grant, restart;
    logic       expire, take_nmi, take_rst;

    assign hit_ctl = (addr == CTL_ADDR);
    assign wr_ctl  = wr && hit_ctl && !rst_out;

    assign take_nmi = expire && (cfg.act == ACT_NMI) && !flags.nmi;
    assign take_rst = expire && !take_nmi;

    wdt_keyseq u_keys (
        .clk      (clk),
        .rst      (rst),
        .flush    (take_rst),
        .wr_ctl   (wr_ctl),
        .wdata    (wdata),
        .wr_grant (wr_grant),
        .restart  (restart)
    );

    wdt_regs #(.DEF_SEL(DEF_SEL)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (take_rst),
        .wr_grant  (wr_grant),
        .wr_data   (decode_wr(wdata)),
        .set_nmi   (take_nmi),
        .set_rst   (take_rst),
        .cfg       (cfg),
        .flags     (flags),
        .locked    (locked),
        .arm_pulse (arm_pulse)
    );

    wdt_timer #(.TAP_BASE(TAP_BASE)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (cfg.en && !rst_out),
        .clr    (restart || arm_pulse),
        .sel    (cfg.sel),
        .expire (expire)
    );

    wdt_rstgen #(.RST_LEN(RST_LEN)) u_rstgen (
        .clk     (clk),
        .rst     (rst),
        .fire    (take_rst),
        .rst_out (rst_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_req     <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            nmi_req     <= take_nmi;
            sys_rst_req <= take_rst;
        end
    end

    assign rdata = hit_ctl ? pack_ctl(cfg, flags) : '0;

endmodule

// File: rtl/wdt_ctrl_chk.sv
`timescale 1ns/1ps
module wdt_ctrl_chk #(
    parameter int unsigned RST_LEN = 65536
)(
    input logic clk,
    input logic rst,
    input logic nmi_req,
    input logic sys_rst_req,
    input logic rst_out,
    input logic nmi_flag,
    input logic rst_flag,
    input logic locked,
    input logic cfg_en
);

    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_out) hi_cnt <= 0;
        else                 hi_cnt <= hi_cnt + 1;
    end

    p_nmi_flag_r7: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> nmi_flag);

    p_nmi_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(nmi_req && sys_rst_req));

    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    p_rstout_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> sys_rst_req);

    p_rst_flag_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> rst_flag && rst_out);

    p_rstout_len_r9: assert property (@(posedge clk) disable iff (rst)
        rst_out |-> hi_cnt < RST_LEN);

    p_nflag_src_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_flag) |-> nmi_req);

    p_rflag_src_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_flag) |-> sys_rst_req);

    p_lock_en_r6: assert property (@(posedge clk) disable iff (rst)
        locked |-> cfg_en);

    p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked || sys_rst_req);

    p_no_nmi_hold_r11: assert property (@(posedge clk) disable iff (rst)
        rst_out |-> !nmi_req);

endmodule

bind wdt_ctrl wdt_ctrl_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .nmi_req     (nmi_req),
    .sys_rst_req (sys_rst_req),
    .rst_out     (rst_out),
    .nmi_flag    (flags.nmi),
    .rst_flag    (flags.rst),
    .locked      (locked),
    .cfg_en      (cfg.en)
);

// File: tb/wdt_ctrl_tb.sv
`timescale 1ns/1ps
module wdt_ctrl_tb;

    localparam int TB_TAP = 4;
    localparam int TB_RL  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic [15:0] rdata;
    logic        nmi_req, sys_rst_req, rst_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    wdt_ctrl #(
        .ADDR_W   (4),
        .CTL_ADDR (4'd0),
        .TAP_BASE (TB_TAP),
        .RST_LEN  (TB_RL),
        .DEF_SEL  (3'd0)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .addr        (addr),
        .wdata       (wdata),
        .wr          (wr),
        .rdata       (rdata),
        .nmi_req     (nmi_req),
        .sys_rst_req (sys_rst_req),
        .rst_out     (rst_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int exp_lim(input logic [2:0] s);
        return 1 << (TB_TAP + 2 * int'(s));
    endfunction

    function automatic logic [15:0] exp_ctl(input logic en, input logic nf, input logic rf,
                                           input logic act, input logic [2:0] s);
        return {en, nf, rf, 9'b0, act, s};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
        addr  = '0;
    endtask

    task automatic kwr(input logic [15:0] d);
        bus_wr(4'd0, 16'h3333);
        bus_wr(4'd0, 16'hCCCC);
        bus_wr(4'd0, d);
    endtask

    task automatic krestart();
        bus_wr(4'd0, 16'hAAAA);
        bus_wr(4'd0, 16'h5555);
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v    = rdata;
        addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_out(input int t0, output int dt, output logic gn, output logic gr);
        int guard;
        guard = 0;
        while (!nmi_req && !sys_rst_req && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        gn = nmi_req;
        gr = sys_rst_req;
        dt = cyc - t0;
    endtask

    task automatic wait_fall(output int hi);
        int t;
        t = cyc;
        while (rst_out && (cyc - t) < 5000) @(negedge clk);
        hi = cyc - t;
    endtask

    initial begin
        logic [15:0] v;
        int t0, dt, hi, seed;
        logic gn, gr, any;

        seed = $urandom(32'd20240611);

        // R1: reset state
        do_reset();
        t0 = cyc;
        rd(4'd0, v);
        chk("R1 reset readback", int'(v), int'(exp_ctl(1, 0, 0, 0, 3'd0)));
        chk("R1 outputs low", int'({nmi_req, sys_rst_req, rst_out}), 0);

        // R2: missing or broken keys
        bus_wr(4'd0, 16'h0000);
        rd(4'd0, v);
        chk("R2 unkeyed write ignored", int'(v), 16'h8000);
        bus_wr(4'd0, 16'h3333);
        bus_wr(4'd0, 16'h1234);
        bus_wr(4'd0, 16'h0000);
        rd(4'd0, v);
        chk("R2 aborted key", int'(v), 16'h8000);
        // R12: key to another address does not count
        bus_wr(4'd1, 16'h3333);
        bus_wr(4'd1, 16'hCCCC);
        bus_wr(4'd0, 16'h0000);
        rd(4'd0, v);
        chk("R12 key at other address", int'(v), 16'h8000);
        rd(4'd1, v);
        chk("R12 other address reads 0", int'(v), 0);

        // R4/R9/R3: default reset time-out, plain traffic did not restart it
        wait_out(t0, dt, gn, gr);
        chk("R4 default period", dt, exp_lim(3'd0));
        chk("R9 reset action", int'({gn, gr, rst_out}), 3'b011);
        t0 = cyc;
        rd(4'd0, v);
        chk("R11 defaults with rst flag", int'(v), int'(exp_ctl(1, 0, 1, 0, 3'd0)));
        kwr(16'h2005);
        chk("R9 one-cycle request", int'(sys_rst_req), 0);
        while (rst_out && (cyc - t0) < 5000) @(negedge clk);
        chk("R9 rst_out length", cyc - t0, TB_RL);
        rd(4'd0, v);
        chk("R11 write during hold ignored", int'(v), 16'hA000);
        t0 = cyc;
        wait_out(t0, dt, gn, gr);
        chk("R11 count resumes from zero", dt, exp_lim(3'd0));
        wait_fall(hi);

        // R5: unlocked rewrites and disabled watchdog
        kwr(16'h2002);
        rd(4'd0, v);
        chk("R5 first rewrite", int'(v), 16'h2002);
        kwr(16'h2003);
        rd(4'd0, v);
        chk("R5 second rewrite", int'(v), 16'h2003);
        any = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (nmi_req || sys_rst_req) any = 1'b1;
        end
        chk("R5 disabled gives no time-out", int'(any), 0);

        // R6: enabling write locks and restarts
        kwr(16'hA00A);
        t0 = cyc;
        rd(4'd0, v);
        chk("R6 enable readback", int'(v), 16'hA00A);
        kwr(16'h2001);
        rd(4'd0, v);
        chk("R6 locked config", int'(v), 16'hA00A);
        wait_out(t0, dt, gn, gr);
        chk("R6 period from enabling write", dt, exp_lim(3'd2));
        chk("R7 NMI without reset", int'({gn, gr}), 2'b10);
        @(negedge clk);
        chk("R7 one-cycle NMI", int'(nmi_req), 0);
        rd(4'd0, v);
        chk("R7 NMI flag set", int'(v), 16'hE00A);

        // R3/R8: restart key, then escalation
        repeat (100) @(negedge clk);
        krestart();
        t0 = cyc;
        wait_out(t0, dt, gn, gr);
        chk("R3 period from restart key", dt, exp_lim(3'd2));
        chk("R8 second time-out resets", int'({gn, gr}), 2'b01);
        rd(4'd0, v);
        chk("R8 flags kept, defaults back", int'(v), 16'hE000);
        wait_fall(hi);

        // R10: flag clearing
        kwr(16'h6000);
        rd(4'd0, v);
        chk("R10 write 1 keeps flags", int'(v), 16'h6000);
        kwr(16'h2000);
        rd(4'd0, v);
        chk("R10 clear NMI flag", int'(v), 16'h2000);
        kwr(16'h0000);
        rd(4'd0, v);
        chk("R10 clear reset flag", int'(v), 16'h0000);
        kwr(16'h6000);
        rd(4'd0, v);
        chk("R10 flags cannot be set", int'(v), 16'h0000);

        // constrained random rounds
        for (int it = 0; it < 10; it++) begin
            logic       md;
            logic [2:0] sl;
            int         junk, lim;
            do_reset();
            rd(4'd0, v);
            chk("R10 external reset clears flags", int'(v), 16'h8000);
            md  = 1'($urandom % 2);
            sl  = 3'($urandom % 3);
            lim = exp_lim(sl);
            kwr(exp_ctl(1, 0, 0, md, sl));
            t0 = cyc;
            rd(4'd0, v);
            chk("R6 random config", int'(v), int'(exp_ctl(1, 0, 0, md, sl)));
            junk = int'($urandom % 5);
            for (int j = 0; j < junk; j++)
                bus_wr(4'($urandom % 16), 16'($urandom) & 16'h0FF1);
            if ($urandom % 2 == 1) begin
                repeat (int'($urandom % 5)) @(negedge clk);
                krestart();
                t0 = cyc;
            end
            wait_out(t0, dt, gn, gr);
            chk("R4 random period", dt, lim);
            chk("R7 random action", int'({gn, gr}), md ? 2'b10 : 2'b01);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule